// File: doc/BRIEF.md
# Minute Alarm Comparator with Level Interrupt

This block watches the running calendar time and raises an alarm when the current minute, hour, day of month and weekday agree with four programmable alarm registers. A calendar core next to it supplies the time as BCD fields and a one-cycle strobe on each minute rollover, in the cycle where seconds wrap to 00. The alarm has one-minute resolution, so the block does not look at seconds.

Every alarm register has its own exclude bit. When that bit is set, the field takes no part in the match, so an alarm can repeat hourly, daily or weekly. A match sets a sticky flag. When the interrupt enable is also set, an active-low level interrupt output stays asserted until software clears the flag through a byte-wide register port.

Top module: `alm_unit`

## Requirements
- R1: After reset the alarm flag and the interrupt enable are 0. Each of the four alarm registers reads 0x80 (excluded). `alarm_irq_n` is 1.
- R2: The alarm registers sit at addresses 0x9 (minute), 0xA (hour), 0xB (day) and 0xC (weekday). Each stores and reads back all 8 written bits. Control register 0x1 reads the alarm flag at bit 3 and the enable at bit 1, with every other bit 0. Any other address reads 0.
- R3: On a cycle with `tick_min` high, the flag is set at the next clock edge when every included field equals the matching time input. Minute is compared on bits 6:0, hour and day on bits 5:0, weekday on bits 2:0. A mismatch in any included field leaves the flag unchanged.
- R4: The flag is never set in a cycle without `tick_min`, even when the time matches.
- R5: A field whose register has bit 7 set does not affect the match.
- R6: When all four alarm registers have bit 7 set, no strobe ever sets the flag.
- R7: `alarm_irq_n` is 0 exactly while the flag and the enable are both 1. It stays low from cycle to cycle until the flag or the enable is cleared.
- R8: A write to 0x1 with bit 3 = 0 clears the flag. A write with bit 3 = 1 leaves the flag as it was, so software can never set it. Bit 1 of the write sets the enable.
- R9: If a matching strobe and a flag-clearing write to 0x1 fall in the same cycle, the flag ends up set.
- R10: Writes to addresses other than 0x1 and 0x9 to 0xC change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_min | input | 1 | One-cycle minute rollover strobe |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq_n | output | 1 | Active-low level alarm interrupt |

## Verification
A matching minute strobe and a software write that clears the flag can land in the same clock cycle. This race decides whether an alarm is lost while the handler clears the previous one. The bench provokes it in a directed case and through random steps that pair strobes with control writes. A bench model applies the clear first and the hardware set second. After each edge, the flag read back and the interrupt level must both show the alarm still pending. A second coincidence is a write to an alarm register in the cycle of a strobe; the match must use the value held before that write.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int N_FIELDS  = 4;
    localparam int EXCL_BIT  = DATA_W - 1;
    localparam logic [ADDR_W-1:0] CTL_ADDR  = 4'h1;
    localparam logic [ADDR_W-1:0] ALM_BASE  = 4'h9;
    localparam int FLAG_BIT  = 3;
    localparam int IEN_BIT   = 1;

    typedef logic [N_FIELDS-1:0][DATA_W-1:0] field_vec_t;

    typedef struct packed {
        field_vec_t alm;
        logic       flag;
        logic       ien;
    } regs_t;

    // Significant bits of each field: 0 minute, 1 hour, 2 day, 3 weekday
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            0:       return 8'h7f;
            1, 2:    return 8'h3f;
            default: return 8'h07;
        endcase
    endfunction
endpackage

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  field_vec_t alm_i,
    input  field_vec_t now_i,
    input  logic       tick_i,
    output logic       hit_o
);
    logic [N_FIELDS-1:0] incl;
    logic [N_FIELDS-1:0] ok;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        localparam logic [DATA_W-1:0] MASK = field_mask(g);
        assign incl[g] = ~alm_i[g][EXCL_BIT];
        // An excluded field always agrees
        assign ok[g]   = ~incl[g] | ((alm_i[g] & MASK) == (now_i[g] & MASK));
    end

    assign hit_o = tick_i & (|incl) & (&ok);
endmodule

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              set_i,
    output field_vec_t        alm_o,
    output logic              flag_o,
    output logic              ien_o,
    output logic [DATA_W-1:0] rdata_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (addr_i == CTL_ADDR) begin
                r_d.ien  = wdata_i[IEN_BIT];
                r_d.flag = r_q.flag & wdata_i[FLAG_BIT];
            end
            for (int i = 0; i < N_FIELDS; i++) begin
                if (addr_i == ALM_BASE + ADDR_W'(i)) r_d.alm[i] = wdata_i;
            end
        end
        // hardware event has priority over software clear
        if (set_i) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_FIELDS; i++) r_q.alm[i] <= DATA_W'(1) << EXCL_BIT;
            r_q.flag <= 1'b0;
            r_q.ien  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTL_ADDR) begin
            rdata_o[FLAG_BIT] = r_q.flag;
            rdata_o[IEN_BIT]  = r_q.ien;
        end
        for (int i = 0; i < N_FIELDS; i++) begin
            if (addr_i == ALM_BASE + ADDR_W'(i)) rdata_o = r_q.alm[i];
        end
    end

    assign alm_o  = r_q.alm;
    assign flag_o = r_q.flag;
    assign ien_o  = r_q.ien;

    // R4: a rising flag must come from a hardware set
    p_set_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(set_i));
    // R8: flag is sticky unless a clearing write occurs
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !(wr_i && addr_i == CTL_ADDR && !wdata_i[FLAG_BIT])) |=> r_q.flag);
    // R9: a set always lands, even against a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> r_q.flag);
endmodule

// File: rtl/alm_unit.sv
module alm_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_min,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_day,
    input  logic [2:0]        cur_wday,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alarm_irq_n
);
    field_vec_t now, alm;
    logic hit, flag, ien;

    assign now[0] = DATA_W'(cur_min);
    assign now[1] = DATA_W'(cur_hour);
    assign now[2] = DATA_W'(cur_day);
    assign now[3] = DATA_W'(cur_wday);

    alm_match u_match (
        .alm_i (alm),
        .now_i (now),
        .tick_i(tick_min),
        .hit_o (hit)
    );

    alm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .addr_i (reg_addr),
        .wdata_i(reg_wdata),
        .set_i  (hit),
        .alm_o  (alm),
        .flag_o (flag),
        .ien_o  (ien),
        .rdata_o(reg_rdata)
    );

    assign alarm_irq_n = ~(flag & ien);

    // R6: with every field excluded a strobe never raises the flag
    p_all_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_min && alm[0][EXCL_BIT] && alm[1][EXCL_BIT] && alm[2][EXCL_BIT] && alm[3][EXCL_BIT])
        |=> !$rose(flag));
    // R7: the interrupt level holds until software writes
    p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_irq_n && !reg_wr) |=> !alarm_irq_n);
    // R4: no strobe, no new interrupt from an already enabled unit
    p_no_tick_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq_n && !tick_min && !reg_wr) |=> alarm_irq_n);
endmodule

// File: tb/tb_alm_unit.sv
module tb_alm_unit;
    logic clk = 0, rst_n = 0;
    logic tick_min = 0, reg_wr = 0;
    logic [6:0] cur_min = 0;
    logic [5:0] cur_hour = 0, cur_day = 0;
    logic [2:0] cur_wday = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic alarm_irq_n;

    int errors = 0, checks = 0;
    logic [7:0] m_alm [4];
    logic m_flag, m_en;

    always #10 clk = ~clk;

    alm_unit dut (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(int i);
        return (i == 0) ? 8'h7f : (i == 3) ? 8'h07 : 8'h3f;
    endfunction

    function automatic logic model_hit(logic [7:0] t0, logic [7:0] t1, logic [7:0] t2, logic [7:0] t3);
        logic [7:0] t [4];
        logic any = 0, all = 1;
        t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
        for (int i = 0; i < 4; i++) begin
            if (!m_alm[i][7]) begin
                any = 1;
                if ((m_alm[i] & mask_of(i)) != (t[i] & mask_of(i))) all = 0;
            end
        end
        return any && all;
    endfunction

    // one clock step: drive at negedge, update model at the edge, check next negedge
    task automatic step(logic tk, logic wr, logic [3:0] a, logic [7:0] wd,
                        logic [6:0] mi, logic [5:0] hr, logic [5:0] dy, logic [2:0] wk, string req);
        logic hit;
        tick_min = tk; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        cur_min = mi; cur_hour = hr; cur_day = dy; cur_wday = wk;
        hit = tk && model_hit(8'(mi), 8'(hr), 8'(dy), 8'(wk));
        @(posedge clk);
        if (wr) begin
            if (a == 4'h1) begin m_en = wd[1]; m_flag = m_flag & wd[3]; end
            else if (a >= 4'h9 && a <= 4'hc) m_alm[a - 4'h9] = wd;
        end
        if (hit) m_flag = 1;
        @(negedge clk);
        tick_min = 0; reg_wr = 0; reg_addr = 4'h1;
        #1;
        chk(req, reg_rdata, {4'b0, m_flag, 1'b0, m_en, 1'b0});
        chk(req, 8'(alarm_irq_n), 8'(!(m_flag && m_en)));
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] exp, string req);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) m_alm[i] = 8'h80;
        m_flag = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) rd(4'(9 + i), 8'h80, "R1 alarm reset");
        rd(4'h1, 8'h00, "R1 ctl reset");
        chk("R1 irq reset", 8'(alarm_irq_n), 8'h01);

        // R2 program minute 30, hour 12, enable
        step(0, 1, 4'h9, 8'h30, 0, 0, 0, 0, "R2 write min");
        step(0, 1, 4'ha, 8'h12, 0, 0, 0, 0, "R2 write hour");
        step(0, 1, 4'h1, 8'h02, 0, 0, 0, 0, "R2 write ctl");
        rd(4'h9, 8'h30, "R2 min readback");
        rd(4'ha, 8'h12, "R2 hour readback");
        rd(4'h3, 8'h00, "R2 unmapped read");

        // R4 match without strobe
        step(0, 0, 0, 0, 7'h30, 6'h12, 6'h05, 3'd2, "R4 no strobe");
        // R3 mismatch then match
        step(1, 0, 0, 0, 7'h31, 6'h12, 6'h05, 3'd2, "R3 mismatch");
        step(1, 0, 0, 0, 7'h30, 6'h12, 6'h05, 3'd2, "R3 match sets");
        // R7 holds
        repeat (3) step(0, 0, 0, 0, 7'h31, 6'h12, 6'h05, 3'd2, "R7 level held");
        // R8 writing 1 keeps flag, enable off releases irq
        step(0, 1, 4'h1, 8'h08, 0, 0, 0, 0, "R7 enable off");
        step(0, 1, 4'h1, 8'h0a, 0, 0, 0, 0, "R8 write one keeps");
        step(0, 1, 4'h1, 8'h02, 0, 0, 0, 0, "R8 clear");
        step(0, 1, 4'h1, 8'h0a, 0, 0, 0, 0, "R8 cannot set");
        // R5 hour excluded with garbage low bits
        step(0, 1, 4'ha, 8'h92, 0, 0, 0, 0, "R5 exclude hour");
        step(1, 0, 0, 0, 7'h30, 6'h07, 6'h05, 3'd2, "R5 excluded field ignored");
        // R9 strobe match with clearing write
        step(1, 1, 4'h1, 8'h02, 7'h30, 6'h03, 6'h01, 3'd0, "R9 set wins");
        step(0, 1, 4'h1, 8'h02, 0, 0, 0, 0, "R9 clear after");
        // R10 write to other address
        step(0, 1, 4'h5, 8'h00, 0, 0, 0, 0, "R10 other write");
        rd(4'h9, 8'h30, "R10 min unchanged");
        rd(4'ha, 8'h92, "R10 hour unchanged");
        // R6 all excluded, low bits equal the time
        step(0, 1, 4'h9, 8'hb0, 0, 0, 0, 0, "R6 setup");
        step(1, 0, 0, 0, 7'h30, 6'h12, 6'h05, 3'd2, "R6 never matches");
        step(1, 0, 0, 0, 7'h00, 6'h00, 6'h00, 3'd0, "R6 never matches");

        // random mix: R3 R5 R8 R9 against the model
        for (int n = 0; n < 600; n++) begin
            logic tk, wr;
            logic [3:0] a;
            logic [7:0] wd;
            logic [6:0] mi; logic [5:0] hr, dy; logic [2:0] wk;
            tk = ($urandom % 3) == 0;
            wr = ($urandom % 2) == 0;
            case ($urandom % 6)
                0, 1:    a = 4'h1;
                2:       a = 4'h9 + 4'($urandom % 4);
                3:       a = 4'($urandom);
                default: a = 4'h9 + 4'($urandom % 4);
            endcase
            wd = 8'($urandom);
            if (a != 4'h1) wd[7] = ($urandom % 3) == 0;
            if (($urandom % 2) == 0) begin
                mi = 7'(m_alm[0]); hr = 6'(m_alm[1]); dy = 6'(m_alm[2]); wk = 3'(m_alm[3]);
            end else begin
                mi = 7'($urandom); hr = 6'($urandom); dy = 6'($urandom); wk = 3'($urandom);
            end
            step(tk, wr, a, wd, mi, hr, dy, wk, "R3 R9 random");
        end
        for (int i = 0; i < 4; i++) rd(4'(9 + i), m_alm[i], "R2 final readback");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule